// File: doc/BRIEF.md
# Online Application Memory Classifier

The block profiles several applications at run time and sorts each into a memory behaviour class at the end of every profiling interval. Event pulses arrive tagged with an application index: a retired instruction, a last-level cache miss, and a row-buffer access that either hit or missed. Each application has its own saturating counters for these events.

When the interval-end pulse arrives, every application that retired at least one instruction is judged. Its miss intensity is compared against a programmable threshold, expressed in misses per thousand instructions. If the application is memory intensive, its row-buffer hit rate is then compared against a programmable percentage. The judgement uses cross-multiplication, so no divider is needed. A separate flag marks applications below one miss per thousand instructions. A scheduler gives those applications priority instead of a channel of their own.

The class codes and flags are registered. They stay constant until the next interval end. The counters restart at every boundary.

Top module: `app_mem_classifier`

## Requirements
- R1: During and right after synchronous reset every class code is 2'b00 and every very-low flag is 0.
- R2: Events are counted only for the application named by their tag. An application's class and flag depend only on its own events, and the outputs of the other applications are unaffected.
- R3: At a boundary an application is memory intensive when misses*1000 > mpki_thr*instructions (strictly). Otherwise its class becomes 2'b00 (low intensity).
- R4: An intensive application gets class 2'b10 when row_hits*100 > rbh_thr_pct*(row_hits+row_misses), and 2'b01 otherwise. With no row-buffer accesses it gets 2'b01. Code 2'b11 never appears.
- R5: At a boundary the very-low flag becomes 1 exactly when misses*1000 < instructions, and 0 otherwise.
- R6: The class codes and flags change only in the cycle after an interval-end pulse, and hold at all other times.
- R7: An application with zero retired instructions in the interval keeps its previous class code and flag.
- R8: Events presented in the same cycle as the interval-end pulse are counted in the new interval, not the one being judged.
- R9: Every counter saturates at its maximum value instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| epoch_end | input | 1 | Interval-end pulse; triggers judgement and counter restart |
| instr_vld | input | 1 | One retired instruction |
| instr_app | input | APP_W | Application index of the retired instruction |
| miss_vld | input | 1 | One last-level cache miss |
| miss_app | input | APP_W | Application index of the miss |
| rb_vld | input | 1 | One row-buffer access outcome |
| rb_app | input | APP_W | Application index of the row-buffer access |
| rb_hit | input | 1 | 1 = row hit, 0 = row miss |
| mpki_thr | input | THR_W | Intensity threshold in misses per thousand instructions |
| rbh_thr_pct | input | PCT_W | Row-buffer locality threshold in percent |
| app_class | output | 2*NUM_APPS | Class code per application, app i in bits [2i+1:2i] |
| very_low | output | NUM_APPS | Very-low-intensity flag per application |

## Verification
Judging an interval and counting fresh events can coincide: an event may arrive in the very cycle of the interval-end pulse. The bench provokes this by driving an instruction and a miss for one application together with the pulse, after an interval that left that application low-intensity and very-low. The outcome settles where the event went. It went into the judged interval if the class moves at once. It was lost if the class holds after the following boundary. It was counted correctly only if the class stays low and then turns to 2'b01 one boundary later.

// File: rtl/amc_pkg.sv
package amc_pkg;
  typedef enum logic [1:0] {
    CLS_LOW      = 2'b00,
    CLS_HI_SCAT  = 2'b01,
    CLS_HI_LOCAL = 2'b10
  } amc_class_e;
endpackage

// File: rtl/amc_sat_cnt.sv
module amc_sat_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (clr) begin
      q <= inc ? W'(1) : '0;
    end else if (inc && !(&q)) begin
      q <= q + W'(1);
    end
  end
endmodule

// File: rtl/amc_judge.sv
module amc_judge
  import amc_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int THR_W = 16,
  parameter int PCT_W = 7
) (
  input  logic [CNT_W-1:0] n_instr,
  input  logic [CNT_W-1:0] n_miss,
  input  logic [CNT_W-1:0] n_hit,
  input  logic [CNT_W-1:0] n_rbmiss,
  input  logic [THR_W-1:0] thr_mpki,
  input  logic [PCT_W-1:0] thr_pct,
  output logic             valid,
  output amc_class_e       cls,
  output logic             vlow
);
  localparam int PW = CNT_W + THR_W + 11;
  localparam int HW = CNT_W + PCT_W + 8;

  logic [PW-1:0] miss_scaled, instr_scaled, instr_wide;
  logic [HW-1:0] hit_scaled, acc_scaled;
  logic [CNT_W:0] n_acc;
  logic intensive, local_hi;

  always_comb begin
    n_acc        = {1'b0, n_hit} + {1'b0, n_rbmiss};
    miss_scaled  = PW'(n_miss) * PW'(1000);
    instr_scaled = PW'(thr_mpki) * PW'(n_instr);
    instr_wide   = PW'(n_instr);
    hit_scaled   = HW'(n_hit) * HW'(100);
    acc_scaled   = HW'(thr_pct) * HW'(n_acc);
    intensive    = miss_scaled > instr_scaled;
    local_hi     = hit_scaled > acc_scaled;
    valid        = |n_instr;
    vlow         = miss_scaled < instr_wide;
    if (!intensive)    cls = CLS_LOW;
    else if (local_hi) cls = CLS_HI_LOCAL;
    else               cls = CLS_HI_SCAT;
  end
endmodule

// File: rtl/app_mem_classifier.sv
module app_mem_classifier
  import amc_pkg::*;
#(
  parameter int NUM_APPS = 4,
  parameter int CNT_W    = 16,
  parameter int THR_W    = 16,
  parameter int PCT_W    = 7,
  localparam int APP_W   = (NUM_APPS > 1) ? $clog2(NUM_APPS) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  epoch_end,
  input  logic                  instr_vld,
  input  logic [APP_W-1:0]      instr_app,
  input  logic                  miss_vld,
  input  logic [APP_W-1:0]      miss_app,
  input  logic                  rb_vld,
  input  logic [APP_W-1:0]      rb_app,
  input  logic                  rb_hit,
  input  logic [THR_W-1:0]      mpki_thr,
  input  logic [PCT_W-1:0]      rbh_thr_pct,
  output logic [2*NUM_APPS-1:0] app_class,
  output logic [NUM_APPS-1:0]   very_low
);
  for (genvar a = 0; a < NUM_APPS; a++) begin : g_app
    logic [CNT_W-1:0] c_instr, c_miss, c_hit, c_rbm;
    logic             hit_i, instr_i, miss_i, rbm_i;
    logic             j_valid, j_vlow;
    amc_class_e       j_cls;
    logic [1:0]       cls_q;
    logic             vlow_q;

    assign instr_i = instr_vld && (instr_app == APP_W'(a));
    assign miss_i  = miss_vld  && (miss_app  == APP_W'(a));
    assign hit_i   = rb_vld && rb_hit  && (rb_app == APP_W'(a));
    assign rbm_i   = rb_vld && !rb_hit && (rb_app == APP_W'(a));

    amc_sat_cnt #(.W(CNT_W)) u_instr (.clk(clk), .rst(rst), .clr(epoch_end), .inc(instr_i), .q(c_instr));
    amc_sat_cnt #(.W(CNT_W)) u_miss  (.clk(clk), .rst(rst), .clr(epoch_end), .inc(miss_i),  .q(c_miss));
    amc_sat_cnt #(.W(CNT_W)) u_hit   (.clk(clk), .rst(rst), .clr(epoch_end), .inc(hit_i),   .q(c_hit));
    amc_sat_cnt #(.W(CNT_W)) u_rbm   (.clk(clk), .rst(rst), .clr(epoch_end), .inc(rbm_i),   .q(c_rbm));

    amc_judge #(.CNT_W(CNT_W), .THR_W(THR_W), .PCT_W(PCT_W)) u_judge (
      .n_instr(c_instr), .n_miss(c_miss), .n_hit(c_hit), .n_rbmiss(c_rbm),
      .thr_mpki(mpki_thr), .thr_pct(rbh_thr_pct),
      .valid(j_valid), .cls(j_cls), .vlow(j_vlow)
    );

    always_ff @(posedge clk) begin
      if (rst) begin
        cls_q  <= CLS_LOW;
        vlow_q <= 1'b0;
      end else if (epoch_end && j_valid) begin
        cls_q  <= j_cls;
        vlow_q <= j_vlow;
      end
    end

    assign app_class[2*a +: 2] = cls_q;
    assign very_low[a]         = vlow_q;
  end
endmodule

// File: rtl/amc_checker.sv
module amc_checker #(
  parameter int NUM_APPS = 4,
  parameter int THR_W    = 16
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  epoch_end,
  input logic [THR_W-1:0]      mpki_thr,
  input logic [2*NUM_APPS-1:0] app_class,
  input logic [NUM_APPS-1:0]   very_low
);
  assert_reset_R1: assert property (@(posedge clk)
    $past(rst) |-> (app_class == '0 && very_low == '0));

  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && !$past(epoch_end)) |-> ($stable(app_class) && $stable(very_low)));

  for (genvar a = 0; a < NUM_APPS; a++) begin : g_chk
    assert_legal_code_R4: assert property (@(posedge clk) disable iff (rst)
      app_class[2*a +: 2] != 2'b11);

    assert_vlow_is_low_R5: assert property (@(posedge clk) disable iff (rst)
      ($past(!rst) && $past(epoch_end) && $past(mpki_thr) != '0 && very_low[a] && $changed(very_low[a]))
        |-> app_class[2*a +: 2] == 2'b00);
  end
endmodule

bind app_mem_classifier amc_checker #(.NUM_APPS(NUM_APPS), .THR_W(THR_W)) u_amc_checker (
  .clk(clk), .rst(rst), .epoch_end(epoch_end), .mpki_thr(mpki_thr),
  .app_class(app_class), .very_low(very_low)
);

// File: tb/test_app_mem_classifier.sv
module test_app_mem_classifier;
  localparam int NA = 4, CW = 8, TW = 16, PW = 7, AW = 2, NV = 8;

  // vector table: app, instr, miss, row hits, row misses, mpki thr, pct thr, exp class, exp flag
  localparam int V_APP [NV] = '{0,   1,   2,   3,   0,   2,  1,   3};
  localparam int V_NI  [NV] = '{100, 200, 100, 100, 100, 50, 250, 3};
  localparam int V_NM  [NV] = '{5,   0,   2,   1,   2,   5,  1,   3};
  localparam int V_H   [NV] = '{0,   4,   30,  5,   7,   20, 0,   3};
  localparam int V_M   [NV] = '{0,   4,   10,  0,   1,   20, 9,   0};
  localparam int V_T   [NV] = '{10,  10,  10,  10,  20,  10, 10,  10};
  localparam int V_P   [NV] = '{50,  50,  50,  50,  50,  50, 50,  99};
  localparam int V_C   [NV] = '{1,   0,   2,   0,   0,   1,  0,   2};
  localparam int V_VL  [NV] = '{0,   1,   0,   0,   0,   0,  0,   0};

  logic clk = 0, rst = 1, epoch_end = 0;
  logic instr_vld = 0, miss_vld = 0, rb_vld = 0, rb_hit = 0;
  logic [AW-1:0] instr_app = 0, miss_app = 0, rb_app = 0;
  logic [TW-1:0] mpki_thr = 10;
  logic [PW-1:0] rbh_thr_pct = 50;
  logic [2*NA-1:0] app_class;
  logic [NA-1:0] very_low;
  int checks = 0, errors = 0;
  logic [1:0] exp_c [NA];
  logic exp_v [NA];

  always #4 clk = ~clk;

  app_mem_classifier #(.NUM_APPS(NA), .CNT_W(CW), .THR_W(TW), .PCT_W(PW)) i_app_mem_classifier (
    .clk(clk), .rst(rst), .epoch_end(epoch_end),
    .instr_vld(instr_vld), .instr_app(instr_app), .miss_vld(miss_vld), .miss_app(miss_app),
    .rb_vld(rb_vld), .rb_app(rb_app), .rb_hit(rb_hit),
    .mpki_thr(mpki_thr), .rbh_thr_pct(rbh_thr_pct),
    .app_class(app_class), .very_low(very_low)
  );

  task automatic check_all(input string req);
    for (int a = 0; a < NA; a++) begin
      checks++;
      if (app_class[2*a +: 2] !== exp_c[a] || very_low[a] !== exp_v[a]) begin
        errors++;
        $display("FAIL %s app %0d: class %b flag %b, expected class %b flag %b",
                 req, a, app_class[2*a +: 2], very_low[a], exp_c[a], exp_v[a]);
      end
    end
  endtask

  task automatic drive(input int app, input int ni, input int nm, input int nh, input int nr);
    int n = ni;
    if (nm > n) n = nm;
    if (nh + nr > n) n = nh + nr;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      instr_vld = (k < ni); instr_app = AW'(app);
      miss_vld  = (k < nm); miss_app  = AW'(app);
      rb_vld    = (k < nh + nr); rb_hit = (k < nh); rb_app = AW'(app);
    end
    @(negedge clk);
    instr_vld = 0; miss_vld = 0; rb_vld = 0;
  endtask

  task automatic boundary();
    @(negedge clk); epoch_end = 1;
    @(negedge clk); epoch_end = 0;
  endtask

  initial begin
    for (int a = 0; a < NA; a++) begin exp_c[a] = 2'b00; exp_v[a] = 1'b0; end
    repeat (3) @(negedge clk);
    check_all("R1 during reset");
    rst = 0;
    @(negedge clk);
    check_all("R1 after reset");

    // R2 R3 R4 R5: table walk; only the tagged application may change
    for (int v = 0; v < NV; v++) begin
      mpki_thr = TW'(V_T[v]); rbh_thr_pct = PW'(V_P[v]);
      drive(V_APP[v], V_NI[v], V_NM[v], V_H[v], V_M[v]);
      check_all("R6 hold before boundary");
      boundary();
      exp_c[V_APP[v]] = 2'(V_C[v]); exp_v[V_APP[v]] = V_VL[v][0];
      check_all("R2/R3/R4/R5 vector");
    end

    // R7: an interval without instructions keeps everything
    mpki_thr = 10; rbh_thr_pct = 50;
    drive(2, 0, 4, 3, 3);
    boundary();
    check_all("R7 zero instructions");

    // R8: events in the boundary cycle count for the next interval
    drive(0, 10, 0, 0, 0);
    @(negedge clk);
    epoch_end = 1; instr_vld = 1; instr_app = 0; miss_vld = 1; miss_app = 0;
    @(negedge clk);
    epoch_end = 0; instr_vld = 0; miss_vld = 0;
    exp_c[0] = 2'b00; exp_v[0] = 1'b1;
    check_all("R8 judged interval excludes boundary events");
    boundary();
    exp_c[0] = 2'b01; exp_v[0] = 1'b0;
    check_all("R8 boundary events in next interval");

    // R9: 260 misses saturate at 255; wrap would give 4 and a low class
    mpki_thr = 10000;
    drive(1, 1, 260, 0, 0);
    boundary();
    exp_c[1] = 2'b01; exp_v[1] = 1'b0;
    check_all("R9 saturation");

    // R6: lone boundary mid-stream, then idle cycles
    repeat (5) @(negedge clk);
    check_all("R6 idle hold");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule